// File: doc/BRIEF.md
# Reset and Power-Fail Supervisor

This block merges every reset source of a small mixed-signal device into one internal reset. It also raises a supply warning to a host controller. Comparator results for the power-on level, the brownout level and the power-fail-warning level arrive as synchronous digital flags. A stop-mode flag, a watchdog kick and a narrow host write port are the remaining inputs.

Each reset source behaves differently at the external reset pin:

- A power-on or brownout condition holds the device in reset and pulls the pin for as long as the condition lasts.
- A watchdog timeout pulls the pin for a fixed number of clocks. The internal reset is held for the same interval.
- A host-requested software reset clears the device internally and leaves the pin alone.

After any reset the block sits in initialization mode with the interrupt line low. It stays there until the host writes the init-done bit.

The power-fail flag is sticky. Hardware sets it whenever the supply is under the warning level outside stop mode. Only a host clear or a reset removes it. With its enable bit set, the flag holds the active-low interrupt line low.

Top module: `rst_pf_supervisor`

## Requirements
- R1: While `por_low` is 1, `rst_int`, `rst_pin_drv` and `init_mode` are 1 and `irq_n` is 0, in any mode.
- R2: `bor_low` = 1 with `stop_mode` = 0 resets the block as in R1. With `stop_mode` = 1, `bor_low` has no effect: `rst_int` and `rst_pin_drv` stay 0.
- R3: The watchdog expires when `WDT_TIMEOUT` clock edges pass after the last kick or reset release without a kick. From that edge, `rst_pin_drv` and `rst_int` are 1 for exactly `PULSE_LEN` cycles. Afterwards the block is in initialization mode. No status bit records the event.
- R4: A kick restarts the watchdog count from zero. A kick on the edge where the count would expire wins, and no reset occurs.
- R5: While `stop_mode` is 1, the watchdog count is frozen. Counting resumes from the held value when stop mode ends.
- R6: A write to address 0 with data bit 4 = 1 asserts `rst_int` for one cycle without asserting `rst_pin_drv`. It returns the flag and the enable to 0 and enters initialization mode.
- R7: Initialization mode is entered by any reset and left by a write to address 0 with data bit 0 = 1. `irq_n` is 0 while `init_mode` is 1.
- R8: Outside stop mode, `pfw_low` = 1 sets the power-fail flag on the next edge. In stop mode `pfw_low` does not set it.
- R9: The power-fail flag stays 1 until a write to address 1 with data bit 1 = 0 clears it. Writing bit 1 = 1 leaves it unchanged. A clear in the same cycle as an active `pfw_low` loses, and the flag stays 1.
- R10: Outside initialization mode, `irq_n` is 0 exactly when the power-fail flag is 1 and the enable is 1. The enable is written from data bit 0 of an address-1 write.
- R11: Every reset source returns the power-fail flag and its enable to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_low | input | 1 | Supply below power-on level (synchronous) |
| bor_low | input | 1 | Supply below brownout level (synchronous) |
| pfw_low | input | 1 | Supply below power-fail-warning level |
| stop_mode | input | 1 | Device is in stop mode |
| wdt_kick | input | 1 | Watchdog restart strobe |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = supply status register |
| wr_data | input | 8 | Host write data |
| rst_int | output | 1 | Internal reset, active high |
| rst_pin_drv | output | 1 | 1 = pull the external reset pin low |
| init_mode | output | 1 | Initialization mode flag |
| irq_n | output | 1 | Interrupt line, active low |

## Verification
The flag and interrupt logic is driven with one vector sequence. That sequence covers set and hold, a host clear, a clear that collides with an active warning, warnings inside stop mode, and writes that change only the enable. Together these separate the set priority from the clear path, and the sticky flag from the enable. The directed tests pull the reset pin through each source: power-on, brownout both outside and inside stop mode, a software write and watchdog expiry. They check whether the pin moves, and they measure the pulse length. The watchdog tests place kicks and stop intervals so that expiry lands exactly one edge after a reachable count. An off-by-one in the timeout, in the restart or in the freeze therefore shows up at the pin.

// File: rtl/rst_pf_supervisor.sv
module rst_pf_supervisor #(
  parameter int WDT_TIMEOUT = 4096,
  parameter int PULSE_LEN   = 16
) (
  input  logic       clk,
  input  logic       por_low,
  input  logic       bor_low,
  input  logic       pfw_low,
  input  logic       stop_mode,
  input  logic       wdt_kick,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output logic       rst_int,
  output logic       rst_pin_drv,
  output logic       init_mode,
  output logic       irq_n
);
  localparam int CW = $clog2(WDT_TIMEOUT);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] wdt_cnt;
  logic [PW-1:0] pulse_cnt;
  logic          swr_q, init_q, pf_flag, pf_en;

  logic hard_rst, pulse_on, soft_rst, wr_ctl, wr_st1, wdt_expire;

  assign hard_rst   = por_low | (bor_low & ~stop_mode);
  assign pulse_on   = (pulse_cnt != '0);
  assign soft_rst   = swr_q | pulse_on;
  assign wr_ctl     = wr_en & ~wr_addr;
  assign wr_st1     = wr_en & wr_addr;
  assign wdt_expire = ~stop_mode & ~wdt_kick & (wdt_cnt == CW'(WDT_TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (hard_rst) begin
      wdt_cnt   <= '0;
      pulse_cnt <= '0;
      swr_q     <= 1'b0;
      init_q    <= 1'b1;
      pf_flag   <= 1'b0;
      pf_en     <= 1'b0;
    end else if (soft_rst) begin
      wdt_cnt   <= '0;
      pulse_cnt <= pulse_on ? pulse_cnt - 1'b1 : '0;
      swr_q     <= 1'b0;
      init_q    <= 1'b1;
      pf_flag   <= 1'b0;
      pf_en     <= 1'b0;
    end else begin
      swr_q <= wr_ctl & wr_data[4];
      if (wr_ctl & wr_data[0]) init_q <= 1'b0;
      if (wdt_kick)        wdt_cnt <= '0;
      else if (stop_mode)  wdt_cnt <= wdt_cnt;
      else if (wdt_expire) begin
        wdt_cnt   <= '0;
        pulse_cnt <= PW'(PULSE_LEN);
      end else             wdt_cnt <= wdt_cnt + 1'b1;
      if (wr_st1) pf_en <= wr_data[0];
      if (pfw_low & ~stop_mode)      pf_flag <= 1'b1;
      else if (wr_st1 & ~wr_data[1]) pf_flag <= 1'b0;
    end
  end

  assign rst_int     = hard_rst | soft_rst;
  assign rst_pin_drv = hard_rst | pulse_on;
  assign init_mode   = init_q | rst_int;
  assign irq_n       = ~(init_mode | (pf_flag & pf_en));
endmodule

// File: rtl/rst_pf_supervisor_chk.sv
module rst_pf_supervisor_chk #(
  parameter int WDT_TIMEOUT = 4096
) (
  input logic                           clk,
  input logic                           por_low,
  input logic                           bor_low,
  input logic                           pfw_low,
  input logic                           stop_mode,
  input logic                           wdt_kick,
  input logic                           wr_en,
  input logic                           wr_addr,
  input logic [7:0]                     wr_data,
  input logic                           rst_int,
  input logic                           rst_pin_drv,
  input logic                           init_mode,
  input logic                           irq_n,
  input logic [$clog2(WDT_TIMEOUT)-1:0] wdt_cnt,
  input logic                           pf_flag,
  input logic                           pf_en
);
  localparam int CW = $clog2(WDT_TIMEOUT);

  p_pin_source_r3: assert property (@(posedge clk) disable iff (por_low)
    ($rose(rst_pin_drv) && !bor_low) |-> ($past(wdt_cnt) == CW'(WDT_TIMEOUT - 1)));

  p_kick_restart_r4: assert property (@(posedge clk) disable iff (por_low)
    (wdt_kick && !rst_int) |=> (wdt_cnt == '0));

  p_stop_freeze_r5: assert property (@(posedge clk) disable iff (por_low)
    (stop_mode && !wdt_kick && !rst_int && !wr_en) |=> $stable(wdt_cnt));

  p_swr_enter_r6: assert property (@(posedge clk) disable iff (por_low)
    (wr_en && !wr_addr && wr_data[4] && !rst_int) |=> (rst_int && init_mode));

  p_swr_no_pin_r6: assert property (@(posedge clk) disable iff (por_low)
    (wr_en && !wr_addr && wr_data[4] && !rst_int && (wdt_cnt != CW'(WDT_TIMEOUT - 1)))
    |=> (rst_pin_drv == (bor_low && !stop_mode)));

  p_pf_set_r8: assert property (@(posedge clk) disable iff (por_low)
    (pfw_low && !stop_mode && !rst_int && pf_en && !(wr_en && wr_addr)) |=> !irq_n);

  p_pf_sticky_r9: assert property (@(posedge clk) disable iff (por_low)
    (pf_flag && !rst_int && !(wr_en && wr_addr && !wr_data[1])) |=> pf_flag);
endmodule

bind rst_pf_supervisor rst_pf_supervisor_chk #(.WDT_TIMEOUT(WDT_TIMEOUT)) u_chk (.*);

// File: tb/sim_rst_pf_supervisor.sv
module sim_rst_pf_supervisor;
  localparam int T = 40;
  localparam int P = 5;

  logic clk = 1'b0;
  logic por_low = 1'b1, bor_low = 1'b0, pfw_low = 1'b0, stop_mode = 1'b0;
  logic wdt_kick = 1'b0, wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rst_int, rst_pin_drv, init_mode, irq_n;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rst_pf_supervisor #(.WDT_TIMEOUT(T), .PULSE_LEN(P)) u0 (
    .clk(clk), .por_low(por_low), .bor_low(bor_low), .pfw_low(pfw_low),
    .stop_mode(stop_mode), .wdt_kick(wdt_kick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rst_int(rst_int), .rst_pin_drv(rst_pin_drv),
    .init_mode(init_mode), .irq_n(irq_n));

  // {pfw_low, stop_mode, wr_en, wr_addr, wr_data, expected irq_n}
  localparam logic [12:0] VEC [11] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 1'b1},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'h01, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h03, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 1'b1},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic kick();
    wdt_kick = 1'b1;
    tick();
    wdt_kick = 1'b0;
  endtask

  task automatic leave_init();
    wr(1'b0, 8'h01);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    check1("R1 rst_int", rst_int, 1'b1);
    check1("R1 pin", rst_pin_drv, 1'b1);
    check1("R1 init", init_mode, 1'b1);
    check1("R1 irq_n", irq_n, 1'b0);
    por_low = 1'b0;
    tick();
    check1("R1 release rst_int", rst_int, 1'b0);
    check1("R7 init after reset", init_mode, 1'b1);
    check1("R7 irq_n in init", irq_n, 1'b0);
    leave_init();
    check1("R7 init exit", init_mode, 1'b0);
    check1("R7 irq_n idle", irq_n, 1'b1);

    kick();
    for (int i = 0; i < 11; i++) begin
      pfw_low = VEC[i][12]; stop_mode = VEC[i][11];
      wr_en = VEC[i][10]; wr_addr = VEC[i][9]; wr_data = VEC[i][8:1];
      tick();
      wr_en = 1'b0;
      check1($sformatf("R8/R9/R10 vector %0d irq_n", i), irq_n, VEC[i][0]);
    end
    pfw_low = 1'b0; stop_mode = 1'b0; wr_data = 8'h00;

    // R2: brownout outside and inside stop mode
    kick();
    bor_low = 1'b1;
    tick();
    check1("R2 bor rst_int", rst_int, 1'b1);
    check1("R2 bor pin", rst_pin_drv, 1'b1);
    stop_mode = 1'b1;
    tick();
    check1("R2 bor in stop rst_int", rst_int, 1'b0);
    check1("R2 bor in stop pin", rst_pin_drv, 1'b0);
    bor_low = 1'b0; stop_mode = 1'b0;
    leave_init();
    pfw_low = 1'b1;
    tick();
    pfw_low = 1'b0;
    check1("R11 enable cleared by bor", irq_n, 1'b1);
    wr(1'b1, 8'h00);

    // R3: watchdog expiry and pulse length
    wr(1'b1, 8'h01);
    pfw_low = 1'b1;
    tick();
    pfw_low = 1'b0;
    check1("R10 irq before wdt", irq_n, 1'b0);
    kick();
    repeat (T - 1) tick();
    check1("R3 pin before expiry", rst_pin_drv, 1'b0);
    tick();
    check1("R3 pin at expiry", rst_pin_drv, 1'b1);
    check1("R3 rst_int at expiry", rst_int, 1'b1);
    repeat (P - 1) tick();
    check1("R3 pin last pulse cycle", rst_pin_drv, 1'b1);
    tick();
    check1("R3 pin after pulse", rst_pin_drv, 1'b0);
    check1("R3 rst_int after pulse", rst_int, 1'b0);
    check1("R3 init after wdt", init_mode, 1'b1);
    leave_init();
    check1("R11 flag cleared by wdt", irq_n, 1'b1);

    // R4: kick on the expiring edge
    kick();
    repeat (T - 1) tick();
    kick();
    check1("R4 kick at limit", rst_pin_drv, 1'b0);
    repeat (T - 1) tick();
    check1("R4 restart before expiry", rst_pin_drv, 1'b0);
    tick();
    check1("R4 restart expiry", rst_pin_drv, 1'b1);
    repeat (P) tick();
    leave_init();

    // R5: stop freezes the count; brownout ignored during stop
    kick();
    repeat (9) tick();
    stop_mode = 1'b1;
    repeat (50) tick();
    check1("R5 frozen pin", rst_pin_drv, 1'b0);
    bor_low = 1'b1;
    repeat (3) tick();
    check1("R2 bor ignored in stop", rst_int, 1'b0);
    bor_low = 1'b0;
    repeat (10) tick();
    stop_mode = 1'b0;
    repeat (T - 10) tick();
    check1("R5 resume before expiry", rst_pin_drv, 1'b0);
    tick();
    check1("R5 resume expiry", rst_pin_drv, 1'b1);
    repeat (P) tick();
    leave_init();

    // R6: software reset
    kick();
    wr(1'b1, 8'h01);
    pfw_low = 1'b1;
    tick();
    pfw_low = 1'b0;
    check1("R10 irq before swr", irq_n, 1'b0);
    wr(1'b0, 8'h10);
    check1("R6 swr rst_int", rst_int, 1'b1);
    check1("R6 swr pin untouched", rst_pin_drv, 1'b0);
    check1("R6 swr init", init_mode, 1'b1);
    tick();
    check1("R6 swr one cycle", rst_int, 1'b0);
    check1("R6 swr stays init", init_mode, 1'b1);
    leave_init();
    check1("R6 defaults restored", irq_n, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule